// File: doc/BRIEF.md
# Super I/O Configuration Register File

This block is an I/O-mapped slave that holds the setup registers of a multi-function peripheral controller. Software reaches the registers through a pair of byte-wide ports: the lower address is the configuration/index port and the next address up is the data port. After reset the register space is locked. Only a fixed two-write key on the configuration port opens it, and a separate exit byte closes it again.

While the space is open, a byte written to the configuration port selects a register index, and the data port then reads or writes that register. A few global registers sit at fixed indices: the logical-device selector, the identity bytes and the power enables. Every other implemented index is banked. Each logical device has its own copy of its activation flag, two 16-bit I/O base addresses and two IRQ numbers, and one device also carries a small group of pin-setup bytes. The per-device settings appear on output ports, where the peripheral functions pick them up.

The bus side uses plain single-cycle strobes and has no back-pressure. A write takes effect at the clock edge on which `bus_wr` is high. A read strobe `bus_rd` loads `bus_rdata` at that edge, so the data is valid from the following cycle and holds until the next read. The two strobes are not expected in the same cycle.

Top module: `sio_cfg_regfile`

## Requirements
- R1: Reset leaves the block locked with the index register, the device selector, the power register and every bank cleared to zero. All exported settings read zero, and `bus_rdata` reads 0xFF.
- R2: Writing 0x55 to the configuration port (address `CFG_PORT`, default 0x03F0) on two consecutive configuration-port writes unlocks the space. Any other byte written there between the two key bytes restarts the sequence. Data-port traffic and reads do not count as configuration-port writes.
- R3: While unlocked, writing 0xAA to the configuration port locks the space again. A data-port read afterwards returns 0xFF.
- R4: While locked, data-port writes change nothing, and reads of either port return 0xFF.
- R5: While unlocked, any configuration-port write other than 0xAA loads the index register, and reading the configuration port returns the current index. The index value survives a lock/unlock cycle. Read data is registered and appears one cycle after the read strobe.
- R6: Index 0x07 is the device selector and reads back the full byte written to it. Banked indices reach separate storage for each selected device. With a selector value of `N_DEV` (default 9) or more, banked writes are dropped and banked reads return 0x00.
- R7: The bank layout is as follows. Index 0x30 bit 0 is the activate flag. 0x60/0x61 hold the high/low bytes of the primary base, and 0x62/0x63 the high/low bytes of the secondary base. 0x70 and 0x72 hold the primary and secondary IRQ in bits 3:0. Read-back is zero-extended. Device n drives `dev_active[n]`, `dev_pri_base[16n+:16]`, `dev_sec_base[16n+:16]`, `dev_pri_irq[4n+:4]` and `dev_sec_irq[4n+:4]`.
- R8: Indices 0x20 and 0x21 return the parameters `DEV_ID` (default 0x02) and `DEV_REV` (default 0x01). Writes to them have no effect.
- R9: Index 0x22 is a global byte with read/write access. Bit n drives `pwr_en[n]`, the power enable of device n.
- R10: Only device `GPIO_DEV` (default 8) implements the pin-setup bytes at indices 0xC0 to 0xC7, with read/write access. Other devices read 0x00 at those indices.
- R11: Indices that are not implemented read 0x00, and writes to them are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | I/O address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| cfg_open | output | 1 | High while the register space is unlocked |
| pwr_en | output | 8 | Power enable bit for each device |
| dev_active | output | N_DEV | Activate flag for each device |
| dev_pri_base | output | 16*N_DEV | Primary I/O base for each device |
| dev_sec_base | output | 16*N_DEV | Secondary I/O base for each device |
| dev_pri_irq | output | 4*N_DEV | Primary IRQ number for each device |
| dev_sec_irq | output | 4*N_DEV | Secondary IRQ number for each device |

## Verification
A lock-state machine that has drifted into the wrong state shows up at the next data-port read. An open space returns register contents where 0xFF was due, and a closed one returns 0xFF where data was due, one cycle after the strobe. A wrong index or device selector makes the affected write land in another bank. This appears at once as a changed bit on that device's exported base, IRQ or activate outputs, while the intended device's outputs stay unchanged. The bench therefore reads registers back and also compares the exported settings of several devices after a sequence of writes that span devices.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
  typedef enum logic [1:0] {
    ST_LOCKED = 2'd0,
    ST_KEY1   = 2'd1,
    ST_OPEN   = 2'd2
  } lock_st_e;

  localparam logic [7:0] KEY_ENTER = 8'h55;
  localparam logic [7:0] KEY_EXIT  = 8'hAA;

  localparam logic [7:0] IDX_SEL   = 8'h07;
  localparam logic [7:0] IDX_ID    = 8'h20;
  localparam logic [7:0] IDX_REV   = 8'h21;
  localparam logic [7:0] IDX_PWR   = 8'h22;
  localparam logic [7:0] IDX_ACT   = 8'h30;
  localparam logic [7:0] IDX_PB_HI = 8'h60;
  localparam logic [7:0] IDX_PB_LO = 8'h61;
  localparam logic [7:0] IDX_SB_HI = 8'h62;
  localparam logic [7:0] IDX_SB_LO = 8'h63;
  localparam logic [7:0] IDX_PIRQ  = 8'h70;
  localparam logic [7:0] IDX_SIRQ  = 8'h72;
  localparam logic [7:0] IDX_PIN0  = 8'hC0;

  localparam logic [7:0] LOCKED_RD = 8'hFF;
endpackage

// File: rtl/sio_unlock_fsm.sv
module sio_unlock_fsm
  import sio_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_wr,
  input  logic [7:0] key_byte,
  output logic       open,
  output logic       idx_load
);
  lock_st_e st_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= ST_LOCKED;
    end else if (key_wr) begin
      case (st_q)
        ST_LOCKED: st_q <= (key_byte == KEY_ENTER) ? ST_KEY1 : ST_LOCKED;
        ST_KEY1:   st_q <= (key_byte == KEY_ENTER) ? ST_OPEN : ST_LOCKED;
        ST_OPEN:   st_q <= (key_byte == KEY_EXIT)  ? ST_LOCKED : ST_OPEN;
        default:   st_q <= ST_LOCKED;
      endcase
    end
  end

  assign open     = (st_q == ST_OPEN);
  assign idx_load = open && key_wr && (key_byte != KEY_EXIT);

  AST_OPEN_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_OPEN && $past(st_q) != ST_OPEN) |->
      ($past(st_q) == ST_KEY1 && $past(key_wr) && $past(key_byte) == KEY_ENTER)); // R2
  AST_EXIT_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_OPEN && key_wr && key_byte == KEY_EXIT) |=> st_q == ST_LOCKED); // R3
endmodule

// File: rtl/sio_dev_bank.sv
module sio_dev_bank
  import sio_cfg_pkg::*;
#(
  parameter bit HAS_PINS = 1'b0,
  parameter int PIN_REGS = 8,
  parameter int IRQ_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       idx,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata,
  output logic             active,
  output logic [15:0]      pri_base,
  output logic [15:0]      sec_base,
  output logic [IRQ_W-1:0] pri_irq,
  output logic [IRQ_W-1:0] sec_irq
);
  localparam int PIN_AW = (PIN_REGS > 1) ? $clog2(PIN_REGS) : 1;

  logic [7:0] pin_rd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      pri_base <= '0;
      sec_base <= '0;
      pri_irq  <= '0;
      sec_irq  <= '0;
    end else if (wr_en) begin
      case (idx)
        IDX_ACT:   active         <= wdata[0];
        IDX_PB_HI: pri_base[15:8] <= wdata;
        IDX_PB_LO: pri_base[7:0]  <= wdata;
        IDX_SB_HI: sec_base[15:8] <= wdata;
        IDX_SB_LO: sec_base[7:0]  <= wdata;
        IDX_PIRQ:  pri_irq        <= wdata[IRQ_W-1:0];
        IDX_SIRQ:  sec_irq        <= wdata[IRQ_W-1:0];
        default:   ;
      endcase
    end
  end

  generate
    if (HAS_PINS) begin : g_pins
      logic [7:0] pin_q [PIN_REGS];
      logic       pin_hit;
      logic [7:0] pin_off;
      assign pin_off = idx - IDX_PIN0;
      assign pin_hit = (idx >= IDX_PIN0) && (pin_off < 8'(PIN_REGS));
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          for (int k = 0; k < PIN_REGS; k++) pin_q[k] <= '0;
        end else if (wr_en && pin_hit) begin
          pin_q[pin_off[PIN_AW-1:0]] <= wdata;
        end
      end
      assign pin_rd = pin_hit ? pin_q[pin_off[PIN_AW-1:0]] : 8'h00;
    end else begin : g_no_pins
      assign pin_rd = 8'h00;
    end
  endgenerate

  always_comb begin
    case (idx)
      IDX_ACT:   rdata = {7'b0, active};
      IDX_PB_HI: rdata = pri_base[15:8];
      IDX_PB_LO: rdata = pri_base[7:0];
      IDX_SB_HI: rdata = sec_base[15:8];
      IDX_SB_LO: rdata = sec_base[7:0];
      IDX_PIRQ:  rdata = 8'(pri_irq);
      IDX_SIRQ:  rdata = 8'(sec_irq);
      default:   rdata = pin_rd;
    endcase
  end

  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable({active, pri_base, sec_base, pri_irq, sec_irq})); // R6
endmodule

// File: rtl/sio_cfg_regfile.sv
module sio_cfg_regfile
  import sio_cfg_pkg::*;
#(
  parameter logic [15:0] CFG_PORT = 16'h03F0,
  parameter int          N_DEV    = 9,
  parameter int          PIN_DEV  = 8,
  parameter int          PIN_REGS = 8,
  parameter int          IRQ_W    = 4,
  parameter logic [7:0]  DEV_ID   = 8'h02,
  parameter logic [7:0]  DEV_REV  = 8'h01
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [15:0]            bus_addr,
  input  logic                   bus_wr,
  input  logic                   bus_rd,
  input  logic [7:0]             bus_wdata,
  output logic [7:0]             bus_rdata,
  output logic                   cfg_open,
  output logic [7:0]             pwr_en,
  output logic [N_DEV-1:0]       dev_active,
  output logic [16*N_DEV-1:0]    dev_pri_base,
  output logic [16*N_DEV-1:0]    dev_sec_base,
  output logic [IRQ_W*N_DEV-1:0] dev_pri_irq,
  output logic [IRQ_W*N_DEV-1:0] dev_sec_irq
);
  localparam logic [15:0] DATA_PORT = CFG_PORT + 16'd1;
  localparam int          SEL_W     = (N_DEV > 1) ? $clog2(N_DEV) : 1;

  logic       cfg_hit, data_hit, idx_load, sel_ok, data_wr;
  logic [7:0] idx_q, sel_q, pwr_q, rd_val;
  logic [7:0] bank_rd [N_DEV];

  assign cfg_hit  = (bus_addr == CFG_PORT);
  assign data_hit = (bus_addr == DATA_PORT);
  assign sel_ok   = (sel_q < 8'(N_DEV));
  assign data_wr  = bus_wr && data_hit && cfg_open;

  sio_unlock_fsm u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_wr   (bus_wr && cfg_hit),
    .key_byte (bus_wdata),
    .open     (cfg_open),
    .idx_load (idx_load)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
      sel_q <= '0;
      pwr_q <= '0;
    end else begin
      if (idx_load) idx_q <= bus_wdata;
      if (data_wr && idx_q == IDX_SEL) sel_q <= bus_wdata;
      if (data_wr && idx_q == IDX_PWR) pwr_q <= bus_wdata;
    end
  end

  generate
    for (genvar d = 0; d < N_DEV; d++) begin : g_dev
      logic bank_we;
      assign bank_we = data_wr && sel_ok && (sel_q[SEL_W-1:0] == SEL_W'(d));
      sio_dev_bank #(
        .HAS_PINS (d == PIN_DEV),
        .PIN_REGS (PIN_REGS),
        .IRQ_W    (IRQ_W)
      ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bank_we),
        .idx      (idx_q),
        .wdata    (bus_wdata),
        .rdata    (bank_rd[d]),
        .active   (dev_active[d]),
        .pri_base (dev_pri_base[16*d +: 16]),
        .sec_base (dev_sec_base[16*d +: 16]),
        .pri_irq  (dev_pri_irq[IRQ_W*d +: IRQ_W]),
        .sec_irq  (dev_sec_irq[IRQ_W*d +: IRQ_W])
      );
    end
  endgenerate

  always_comb begin
    rd_val = LOCKED_RD;
    if (cfg_hit && cfg_open) begin
      rd_val = idx_q;
    end else if (data_hit && cfg_open) begin
      case (idx_q)
        IDX_SEL: rd_val = sel_q;
        IDX_ID:  rd_val = DEV_ID;
        IDX_REV: rd_val = DEV_REV;
        IDX_PWR: rd_val = pwr_q;
        default: rd_val = sel_ok ? bank_rd[sel_q[SEL_W-1:0]] : 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= LOCKED_RD;
    else if (bus_rd) bus_rdata <= rd_val;
  end

  assign pwr_en = pwr_q;

  AST_LOCKED_READS_FF: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && data_hit && !cfg_open) |=> bus_rdata == LOCKED_RD); // R4
  AST_ID_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && data_hit && cfg_open && idx_q == IDX_ID) |=> bus_rdata == DEV_ID); // R8
  AST_OOR_SEL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && data_hit && cfg_open && !sel_ok && idx_q == IDX_ACT) |=> bus_rdata == 8'h00); // R6
  AST_SEL_STABLE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_open |=> $stable(sel_q)); // R4
endmodule

// File: tb/sio_cfg_regfile_tb.sv
module sio_cfg_regfile_tb_top;
  localparam int N_DEV = 9;

  typedef struct packed {
    logic        rd;
    logic [15:0] a;
    logic [7:0]  d;
    logic [3:0]  req;
  } vec_t;

  localparam logic [15:0] CP = 16'h03F0;
  localparam logic [15:0] DP = 16'h03F1;
  localparam int NV = 63;
  // rd=0: write d; rd=1: read, expect d
  localparam vec_t VEC [NV] = '{
    '{1'b0, CP, 8'h55, 4'd2}, '{1'b0, CP, 8'h55, 4'd2},   // R2 unlock
    '{1'b1, CP, 8'h00, 4'd5},                             // R5 index read
    '{1'b0, CP, 8'h20, 4'd8}, '{1'b1, DP, 8'h02, 4'd8},   // R8 id
    '{1'b0, DP, 8'hFF, 4'd8}, '{1'b1, DP, 8'h02, 4'd8},
    '{1'b0, CP, 8'h21, 4'd8}, '{1'b1, DP, 8'h01, 4'd8},
    '{1'b0, CP, 8'h07, 4'd6}, '{1'b0, DP, 8'h07, 4'd6}, '{1'b1, DP, 8'h07, 4'd6}, // R6
    '{1'b0, CP, 8'h30, 4'd7}, '{1'b0, DP, 8'hFF, 4'd7}, '{1'b1, DP, 8'h01, 4'd7}, // R7
    '{1'b0, CP, 8'h60, 4'd7}, '{1'b0, DP, 8'h12, 4'd7},
    '{1'b0, CP, 8'h61, 4'd7}, '{1'b0, DP, 8'h34, 4'd7}, '{1'b1, DP, 8'h34, 4'd7},
    '{1'b0, CP, 8'h70, 4'd7}, '{1'b0, DP, 8'hF1, 4'd7}, '{1'b1, DP, 8'h01, 4'd7},
    '{1'b0, CP, 8'h07, 4'd6}, '{1'b0, DP, 8'h01, 4'd6},
    '{1'b0, CP, 8'h30, 4'd6}, '{1'b1, DP, 8'h00, 4'd6},   // R6 separate bank
    '{1'b0, DP, 8'h01, 4'd7},
    '{1'b0, CP, 8'h62, 4'd7}, '{1'b0, DP, 8'h03, 4'd7},
    '{1'b0, CP, 8'h63, 4'd7}, '{1'b0, DP, 8'hF6, 4'd7},
    '{1'b0, CP, 8'h72, 4'd7}, '{1'b0, DP, 8'h0E, 4'd7}, '{1'b1, DP, 8'h0E, 4'd7},
    '{1'b0, CP, 8'h22, 4'd9}, '{1'b0, DP, 8'h82, 4'd9}, '{1'b1, DP, 8'h82, 4'd9}, // R9
    '{1'b0, CP, 8'h07, 4'd10}, '{1'b0, DP, 8'h08, 4'd10},
    '{1'b0, CP, 8'hC5, 4'd10}, '{1'b0, DP, 8'h01, 4'd10}, '{1'b1, DP, 8'h01, 4'd10}, // R10
    '{1'b0, CP, 8'hC8, 4'd11}, '{1'b0, DP, 8'h77, 4'd11}, '{1'b1, DP, 8'h00, 4'd11}, // R11
    '{1'b0, CP, 8'h07, 4'd10}, '{1'b0, DP, 8'h01, 4'd10},
    '{1'b0, CP, 8'hC5, 4'd10}, '{1'b1, DP, 8'h00, 4'd10},
    '{1'b0, CP, 8'h50, 4'd11}, '{1'b0, DP, 8'h5A, 4'd11}, '{1'b1, DP, 8'h00, 4'd11},
    '{1'b0, CP, 8'h07, 4'd6}, '{1'b0, DP, 8'h0C, 4'd6},
    '{1'b0, CP, 8'h30, 4'd6}, '{1'b0, DP, 8'h01, 4'd6}, '{1'b1, DP, 8'h00, 4'd6},
    '{1'b0, CP, 8'h07, 4'd6}, '{1'b1, DP, 8'h0C, 4'd6},
    '{1'b0, CP, 8'hAA, 4'd3}, '{1'b1, DP, 8'hFF, 4'd3},   // R3 exit
    '{1'b1, CP, 8'hFF, 4'd4}                              // R4
  };

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic [15:0]            bus_addr = '0;
  logic                   bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]             bus_wdata = '0;
  logic [7:0]             bus_rdata;
  logic                   cfg_open;
  logic [7:0]             pwr_en;
  logic [N_DEV-1:0]       dev_active;
  logic [16*N_DEV-1:0]    dev_pri_base, dev_sec_base;
  logic [4*N_DEV-1:0]     dev_pri_irq, dev_sec_irq;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sio_cfg_regfile dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg_open(cfg_open), .pwr_en(pwr_en),
    .dev_active(dev_active), .dev_pri_base(dev_pri_base), .dev_sec_base(dev_sec_base),
    .dev_pri_irq(dev_pri_irq), .dev_sec_irq(dev_sec_irq)
  );

  task automatic check(input int req, input logic [159:0] act, input logic [159:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [7:0] exp, input int req);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    check(req, 160'(bus_rdata), 160'(exp));
  endtask

  task automatic check_cleared();
    check(1, 160'(cfg_open), 160'(0));          // R1
    check(1, 160'(pwr_en), 160'(0));
    check(1, 160'({dev_active, dev_pri_irq, dev_sec_irq}), 160'(0));
    check(1, 160'(dev_pri_base), 160'(0));
    check(1, 160'(dev_sec_base), 160'(0));
    check(1, 160'(bus_rdata), 160'(8'hFF));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_cleared();                            // R1 reset state
    rd(DP, 8'hFF, 1);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].rd) rd(VEC[i].a, VEC[i].d, int'(VEC[i].req));
      else           wr(VEC[i].a, VEC[i].d);
    end

    // R7 exported settings
    check(7, 160'(dev_active), 160'(9'h082));
    check(7, 160'(dev_pri_base[16*7 +: 16]), 160'(16'h1234));
    check(7, 160'(dev_pri_irq[4*7 +: 4]), 160'(4'h1));
    check(7, 160'(dev_sec_base[16*1 +: 16]), 160'(16'h03F6));
    check(7, 160'(dev_sec_irq[4*1 +: 4]), 160'(4'hE));
    check(9, 160'(pwr_en), 160'(8'h82));        // R9

    // R2 broken key restarts; R4 locked data write ignored
    wr(CP, 8'h55); wr(CP, 8'h12); wr(CP, 8'h55);
    rd(CP, 8'hFF, 2);
    wr(DP, 8'h05);
    check(4, 160'(dev_active), 160'(9'h082));
    wr(CP, 8'h55);
    check(2, 160'(cfg_open), 160'(1));
    rd(CP, 8'h07, 5);                           // R5 index kept
    rd(DP, 8'h0C, 4);                           // selector untouched
    wr(CP, 8'hAA);
    check(3, 160'(cfg_open), 160'(0));

    // R1 reset after configuration
    wr(CP, 8'h55); wr(CP, 8'h55);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check_cleared();
    rd(DP, 8'hFF, 1);
    rd(CP, 8'hFF, 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule